// File: doc/BRIEF.md
# Data Breakpoint Comparator

This block watches the stream of load and store accesses of a processor's data port and flags an access that matches one or more programmed breakpoint channels. Each channel holds a target address, a mask of address bits to leave out of the comparison, an address-space identifier, a 64-bit data value, a per-lane ignore mask and a per-lane data mask, plus control bits. The control bits arm the channel, exclude loads or stores, require a matching address-space identifier, and request a trace trigger.

For every valid access, all channels are evaluated in parallel. The per-channel hit vector, the trigger pulse and the imprecise flags are registered and appear one cycle after the access. A hit on a channel whose data mask leaves any lane compared is a data-filtered break. Such a break is reported as imprecise, with one flag for loads and one for stores. A sticky status vector keeps a record of every channel that has hit. Software clears a status bit by writing 0 to its position. A small write port programs the channel fields, and an output reports how many channels are built.

Top module: `dbrk_unit`

## Requirements
- R1: After reset, `hit_o`, `status_o`, `trig_o`, `imp_ld_o` and `imp_st_o` are all 0, every channel is disarmed, and `num_ch_o` equals the NUM_CH parameter.
- R2: The address comparison works on the doubleword address (`acc_addr[31:3]`). Address bits set in the channel's address mask are left out of the comparison. The result of an access sampled at a clock edge appears on `hit_o` (bit c for channel c) after that edge and lasts one cycle.
- R3: Byte lane i is accessed when `acc_be[i]` is 1. A lane whose ignore bit is set does not count. A hit needs at least one lane that is both accessed and not ignored.
- R4: When the channel's ASID-use control bit is 1, a hit also needs `acc_asid` to equal the programmed ASID. When the bit is 0, the ASID has no effect.
- R5: Byte lane i carries `acc_data[8i+7:8i]`. On every lane that is accessed, not ignored and has its data-mask bit clear, the data byte must equal the programmed byte. Lanes with the data-mask bit set are not compared.
- R6: The no-store control bit keeps stores (`acc_store`=1) from hitting the channel. The no-load control bit keeps loads from hitting it.
- R7: A channel whose enable control bit is 0 never hits.
- R8: `trig_o` pulses for one cycle together with a hit on any channel whose trigger-enable bit is 1. It stays 0 for hits only on channels without that bit.
- R9: `status_o[c]` is set by a hit on channel c and stays set. A status write clears each bit whose write-data bit is 0 and leaves bits whose write-data bit is 1 unchanged. A hit in the same cycle as a clear wins.
- R10: `imp_ld_o` (for a load) or `imp_st_o` (for a store) is 1 together with a hit on any channel whose data mask is not all ones.
- R11: A configuration write with `cfg_we`=1 updates only the field selected by `cfg_field` of channel `cfg_ch`. The field codes are:
  - 0: address, `cfg_wdata[31:0]`
  - 1: address mask, `cfg_wdata[31:0]`
  - 2: ASID, `cfg_wdata[7:0]`
  - 3: data value, `cfg_wdata[63:0]`
  - 4: lane masks, with the ignore mask in `[7:0]` and the data mask in `[15:8]`
  - 5: control, with enable in bit 0, no-store in bit 1, no-load in bit 2, ASID-use in bit 3 and trigger-enable in bit 4

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW (2) | Channel selected for the write |
| cfg_field | input | 3 | Field code (see R11) |
| cfg_wdata | input | 64 | Configuration write data |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | NUM_CH (4) | Status write data (0 clears a bit) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_be | input | 8 | Byte-lane enables |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_asid | input | 8 | Address-space identifier of the access |
| acc_data | input | 64 | Access data |
| hit_o | output | NUM_CH (4) | Per-channel hit, one cycle after the access |
| status_o | output | NUM_CH (4) | Sticky per-channel hit status |
| num_ch_o | output | CNTW (3) | Number of implemented channels |
| trig_o | output | 1 | Trace trigger pulse |
| imp_ld_o | output | 1 | Imprecise data-filtered break on a load |
| imp_st_o | output | 1 | Imprecise data-filtered break on a store |

## Verification
The assertions check several properties on every cycle:
- a hit only ever follows a valid access with a non-empty byte enable, on an armed channel;
- a status bit only falls after a clearing write;
- a hit is always reflected in status;
- a trigger or imprecise flag never appears without a hit, and the two imprecise flags are never set together.

Only the bench's scenarios can show that each match condition decides correctly. That covers the masked address bits, lane ignore against partial byte enables, ASID gating, data compare on masked lanes, and direction exclusion. The scenarios also show that a hit racing a status clear keeps the bit set.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

    localparam int AW      = 32;
    localparam int DW      = 64;
    localparam int LANES   = DW / 8;
    localparam int ASIDW   = 8;
    localparam int DWORD_LSB = $clog2(LANES);

    typedef enum logic [2:0] {
        FLD_ADDR  = 3'd0,
        FLD_AMASK = 3'd1,
        FLD_ASID  = 3'd2,
        FLD_DATA  = 3'd3,
        FLD_LANES = 3'd4,
        FLD_CTRL  = 3'd5
    } cfg_field_e;

    typedef struct packed {
        logic trig_en;
        logic use_asid;
        logic no_load;
        logic no_store;
        logic en;
    } chan_ctrl_t;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [AW-1:0]    amask;
        logic [ASIDW-1:0] asid;
        logic [DW-1:0]    data;
        logic [LANES-1:0] ign;
        logic [LANES-1:0] dmask;
        chan_ctrl_t       ctrl;
    } chan_cfg_t;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
        logic             store;
        logic [ASIDW-1:0] asid;
        logic [DW-1:0]    data;
    } access_t;

    function automatic logic dword_eq(logic [AW-1:0] a, logic [AW-1:0] b,
                                      logic [AW-1:0] mask);
        logic [AW-1:0] diff;
        diff = (a ^ b) & ~mask;
        return diff[AW-1:DWORD_LSB] == '0;
    endfunction

endpackage

// File: rtl/dbrk_chan_regs.sv
module dbrk_chan_regs
    import dbrk_pkg::*;
#(
    parameter int CHW   = 2,
    parameter int CH_ID = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  cfg_field_e     cfg_field,
    input  logic [DW-1:0]  cfg_wdata,
    output chan_cfg_t      cfg_o
);

    chan_cfg_t cfg_q;
    logic      sel;

    assign sel = cfg_we && (cfg_ch == CHW'(CH_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sel) begin
            unique case (cfg_field)
                FLD_ADDR:  cfg_q.addr  <= cfg_wdata[AW-1:0];
                FLD_AMASK: cfg_q.amask <= cfg_wdata[AW-1:0];
                FLD_ASID:  cfg_q.asid  <= cfg_wdata[ASIDW-1:0];
                FLD_DATA:  cfg_q.data  <= cfg_wdata;
                FLD_LANES: begin
                    cfg_q.ign   <= cfg_wdata[LANES-1:0];
                    cfg_q.dmask <= cfg_wdata[2*LANES-1:LANES];
                end
                FLD_CTRL:  cfg_q.ctrl  <= chan_ctrl_t'(cfg_wdata[$bits(chan_ctrl_t)-1:0]);
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dbrk_match.sv
module dbrk_match
    import dbrk_pkg::*;
(
    input  chan_cfg_t cfg,
    input  access_t   acc,
    output logic      hit,
    output logic      filt
);

    logic [LANES-1:0] lane_act;
    logic [LANES-1:0] lane_bad;
    logic             dir_ok;
    logic             addr_ok;
    logic             asid_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_act[i] = acc.be[i] & ~cfg.ign[i];
        assign lane_bad[i] = lane_act[i] & ~cfg.dmask[i] &
                             (acc.data[8*i +: 8] != cfg.data[8*i +: 8]);
    end

    assign dir_ok  = acc.store ? ~cfg.ctrl.no_store : ~cfg.ctrl.no_load;
    assign addr_ok = dword_eq(acc.addr, cfg.addr, cfg.amask);
    assign asid_ok = ~cfg.ctrl.use_asid | (acc.asid == cfg.asid);

    assign hit  = cfg.ctrl.en & dir_ok & addr_ok & asid_ok &
                  (|lane_act) & ~(|lane_bad);
    assign filt = ~(&cfg.dmask);

endmodule

// File: rtl/dbrk_status.sv
module dbrk_status #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [NUM_CH-1:0] hit_in,
    input  logic [NUM_CH-1:0] filt_in,
    input  logic [NUM_CH-1:0] trg_in,
    input  logic              sts_we,
    input  logic [NUM_CH-1:0] sts_wdata,
    output logic [NUM_CH-1:0] hit_q,
    output logic [NUM_CH-1:0] status_q,
    output logic              trig_q,
    output logic              imp_ld_q,
    output logic              imp_st_q
);

    logic [NUM_CH-1:0] hits;
    logic              any_filt;
    logic [NUM_CH-1:0] keep;

    assign hits     = acc_valid ? hit_in : '0;
    assign any_filt = |(hits & filt_in);
    assign keep     = sts_we ? (status_q & sts_wdata) : status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q    <= '0;
            status_q <= '0;
            trig_q   <= 1'b0;
            imp_ld_q <= 1'b0;
            imp_st_q <= 1'b0;
        end else begin
            hit_q    <= hits;
            status_q <= keep | hits;
            trig_q   <= |(hits & trg_in);
            imp_ld_q <= any_filt & ~acc_store;
            imp_st_q <= any_filt & acc_store;
        end
    end

    a_r9_hit_in_status: assert property (@(posedge clk) disable iff (rst)
        (hit_q & ~status_q) == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sticky
        a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
            $fell(status_q[c]) |-> ($past(sts_we) && !$past(sts_wdata[c])));
    end

    a_r8_trig_needs_hit: assert property (@(posedge clk) disable iff (rst)
        trig_q |-> (|hit_q));

    a_r10_imp_needs_hit: assert property (@(posedge clk) disable iff (rst)
        (imp_ld_q || imp_st_q) |-> (|hit_q));

    a_r10_imp_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(imp_ld_q && imp_st_q));

endmodule

// File: rtl/dbrk_unit.sv
module dbrk_unit
    import dbrk_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNTW  = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [2:0]        cfg_field,
    input  logic [63:0]       cfg_wdata,
    input  logic              sts_we,
    input  logic [NUM_CH-1:0] sts_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic [7:0]        acc_be,
    input  logic              acc_store,
    input  logic [7:0]        acc_asid,
    input  logic [63:0]       acc_data,
    output logic [NUM_CH-1:0] hit_o,
    output logic [NUM_CH-1:0] status_o,
    output logic [CNTW-1:0]   num_ch_o,
    output logic              trig_o,
    output logic              imp_ld_o,
    output logic              imp_st_o
);

    access_t           acc;
    chan_cfg_t         cfg_arr [NUM_CH];
    logic [NUM_CH-1:0] hit_v;
    logic [NUM_CH-1:0] filt_v;
    logic [NUM_CH-1:0] trg_v;

    assign acc = '{addr: acc_addr, be: acc_be, store: acc_store,
                   asid: acc_asid, data: acc_data};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbrk_chan_regs #(.CHW(CHW), .CH_ID(c)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we),
            .cfg_ch    (cfg_ch),
            .cfg_field (cfg_field_e'(cfg_field)),
            .cfg_wdata (cfg_wdata),
            .cfg_o     (cfg_arr[c])
        );

        dbrk_match u_match (
            .cfg  (cfg_arr[c]),
            .acc  (acc),
            .hit  (hit_v[c]),
            .filt (filt_v[c])
        );

        assign trg_v[c] = cfg_arr[c].ctrl.trig_en;

        a_r7_armed_only: assert property (@(posedge clk) disable iff (rst)
            hit_o[c] |-> $past(cfg_arr[c].ctrl.en));
    end

    dbrk_status #(.NUM_CH(NUM_CH)) u_status (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_store (acc_store),
        .hit_in    (hit_v),
        .filt_in   (filt_v),
        .trg_in    (trg_v),
        .sts_we    (sts_we),
        .sts_wdata (sts_wdata),
        .hit_q     (hit_o),
        .status_q  (status_o),
        .trig_q    (trig_o),
        .imp_ld_q  (imp_ld_o),
        .imp_st_q  (imp_st_o)
    );

    assign num_ch_o = CNTW'(NUM_CH);

    a_r2_hit_follows_access: assert property (@(posedge clk) disable iff (rst)
        (|hit_o) |-> $past(acc_valid));

    a_r3_hit_needs_lane: assert property (@(posedge clk) disable iff (rst)
        (|hit_o) |-> ($past(acc_be) != '0));

endmodule

// File: tb/dbrk_unit_tb.sv
`timescale 1ns/1ps
module dbrk_unit_tb;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_field = '0;
    logic [63:0] cfg_wdata = '0;
    logic        sts_we = 1'b0;
    logic [N-1:0] sts_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  acc_be = '0;
    logic        acc_store = 1'b0;
    logic [7:0]  acc_asid = '0;
    logic [63:0] acc_data = '0;
    logic [N-1:0] hit_o, status_o;
    logic [2:0]  num_ch_o;
    logic        trig_o, imp_ld_o, imp_st_o;

    always #2.5 clk = ~clk;

    dbrk_unit #(.NUM_CH(N)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .sts_we(sts_we),
        .sts_wdata(sts_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_be(acc_be), .acc_store(acc_store), .acc_asid(acc_asid),
        .acc_data(acc_data), .hit_o(hit_o), .status_o(status_o),
        .num_ch_o(num_ch_o), .trig_o(trig_o), .imp_ld_o(imp_ld_o),
        .imp_st_o(imp_st_o)
    );

    // control bit encodings (R11)
    localparam logic [63:0] C_EN = 64'h01, C_NS = 64'h02, C_NL = 64'h04,
                            C_UA = 64'h08, C_TR = 64'h10;

    int total = 0;
    int bad   = 0;

    // bench copy of programmed channel state
    logic [31:0] m_addr [N];
    logic [31:0] m_amask[N];
    logic [7:0]  m_asid [N];
    logic [63:0] m_data [N];
    logic [7:0]  m_ign  [N];
    logic [7:0]  m_dmask[N];
    logic [4:0]  m_ctrl [N];
    logic [N-1:0] sts_model = '0;

    typedef struct {
        logic [N-1:0] hit;
        logic         trig;
        logic         ild;
        logic         ist;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    logic pend = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic prog(input int ch, input logic [2:0] fld, input logic [63:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_field = fld; cfg_wdata = v;
        case (fld)
            3'd0: m_addr[ch]  = v[31:0];
            3'd1: m_amask[ch] = v[31:0];
            3'd2: m_asid[ch]  = v[7:0];
            3'd3: m_data[ch]  = v;
            3'd4: begin m_ign[ch] = v[7:0]; m_dmask[ch] = v[15:8]; end
            3'd5: m_ctrl[ch]  = v[4:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic [7:0] be,
                                   input logic st, input logic [7:0] asid,
                                   input logic [63:0] d, input string tag);
        exp_t e;
        bit filt;
        e.hit = '0; e.trig = 0; e.ild = 0; e.ist = 0; e.tag = tag;
        filt = 0;
        for (int c = 0; c < N; c++) begin
            logic [7:0] act;
            logic [31:0] diff;
            bit ok;
            act  = be & ~m_ign[c];
            diff = (a ^ m_addr[c]) & ~m_amask[c];
            ok = m_ctrl[c][0] && !(st ? m_ctrl[c][1] : m_ctrl[c][2]) &&
                 (diff[31:3] == 0) && (act != 0) &&
                 (!m_ctrl[c][3] || asid == m_asid[c]);
            for (int i = 0; i < 8; i++)
                if (act[i] && !m_dmask[c][i] && d[8*i +: 8] != m_data[c][8*i +: 8])
                    ok = 0;
            if (ok) begin
                e.hit[c] = 1'b1;
                if (m_ctrl[c][4]) e.trig = 1;
                if (m_dmask[c] != 8'hFF) filt = 1;
            end
        end
        e.ild = filt && !st;
        e.ist = filt && st;
        return e;
    endfunction

    task automatic access(input logic [31:0] a, input logic [7:0] be, input logic st,
                          input logic [7:0] asid, input logic [63:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_be = be; acc_store = st;
        acc_asid = asid; acc_data = d;
        e = model(a, be, st, asid, d, tag);
        sts_model = sts_model | e.hit;
        exp_q.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic clear_status(input logic [N-1:0] w);
        @(negedge clk);
        sts_we = 1'b1; sts_wdata = w;
        sts_model = sts_model & w;
        @(negedge clk);
        sts_we = 1'b0;
    endtask

    task automatic check_status(input string tag);
        @(negedge clk);
        check(status_o == sts_model, tag, "status", 64'(status_o), 64'(sts_model));
    endtask

    // monitor: outputs of an access taken at a posedge are compared at the next negedge
    always @(posedge clk) pend <= acc_valid && !rst;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected result", 64'(hit_o), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(hit_o == e.hit, e.tag, "hit", 64'(hit_o), 64'(e.hit));
                check(trig_o == e.trig, {e.tag, "/R8"}, "trig", 64'(trig_o), 64'(e.trig));
                check(imp_ld_o == e.ild, {e.tag, "/R10"}, "imp_ld", 64'(imp_ld_o), 64'(e.ild));
                check(imp_st_o == e.ist, {e.tag, "/R10"}, "imp_st", 64'(imp_st_o), 64'(e.ist));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_addr[c] = 0; m_amask[c] = 0; m_asid[c] = 0; m_data[c] = 0;
            m_ign[c] = 0; m_dmask[c] = 0; m_ctrl[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(hit_o == 0 && trig_o == 0 && imp_ld_o == 0 && imp_st_o == 0,
              "R1", "outputs after reset", {hit_o, trig_o, imp_ld_o, imp_st_o}, 0);
        check(status_o == 0, "R1", "status after reset", 64'(status_o), 0);
        check(num_ch_o == 3'(N), "R1", "channel count", 64'(num_ch_o), 64'(N));
        access(32'h1000_0040, 8'hFF, 0, 8'h00, 64'h0, "R1 disarmed");

        // channel 0: plain address break (R11 field writes)
        prog(0, 3'd0, 64'h1000_0040);
        prog(0, 3'd4, 64'hFF00);
        prog(1, 3'd0, 64'h1000_0040);
        prog(1, 3'd4, 64'hFF00);
        prog(0, 3'd5, C_EN);
        access(32'h1000_0044, 8'h01, 0, 8'h00, 64'h0, "R2 same dword");
        access(32'h1000_0048, 8'h01, 0, 8'h00, 64'h0, "R2 next dword");
        check_status("R9 set by hit");
        // R7: channel 1 same address but disarmed — covered in hit vector above
        access(32'h1000_0040, 8'hFF, 1, 8'h00, 64'h0, "R7 ch1 disarmed");
        prog(0, 3'd1, 64'h0000_00F0);
        access(32'h1000_00B0, 8'h02, 0, 8'h00, 64'h0, "R2 masked bits");
        access(32'h1000_01B0, 8'h02, 0, 8'h00, 64'h0, "R2 unmasked bit differs");

        // R3: lane ignore
        prog(0, 3'd4, 64'hFF0F);
        access(32'h1000_0040, 8'h0F, 0, 8'h00, 64'h0, "R3 only ignored lanes");
        access(32'h1000_0040, 8'h10, 0, 8'h00, 64'h0, "R3 one live lane");
        access(32'h1000_0040, 8'h00, 0, 8'h00, 64'h0, "R3 no lanes");

        // R4: ASID gating on channel 1 (upper write bits dropped, R11)
        prog(1, 3'd0, 64'h2000_0000);
        prog(1, 3'd2, 64'hFFFF_FFFF_FFFF_FF5A);
        prog(1, 3'd5, C_EN | C_UA);
        access(32'h2000_0004, 8'h01, 0, 8'h5A, 64'h0, "R4 asid equal");
        access(32'h2000_0004, 8'h01, 0, 8'h5B, 64'h0, "R4 asid differs");
        prog(1, 3'd5, C_EN);
        access(32'h2000_0004, 8'h01, 0, 8'h5B, 64'h0, "R4 asid not used");

        // R5 / R8 / R10: data compare on channel 2 with trigger
        prog(2, 3'd0, 64'h3000_0000);
        prog(2, 3'd3, 64'h8877_6655_4433_2211);
        prog(2, 3'd4, 64'hF000);
        prog(2, 3'd5, C_EN | C_TR);
        access(32'h3000_0000, 8'hFF, 0, 8'h00, 64'h8877_6655_4433_2211, "R5 data equal");
        @(negedge clk);
        check(trig_o == 0 && hit_o == 0, "R8", "pulse ends", {trig_o, hit_o}, 0);
        access(32'h3000_0000, 8'hFF, 0, 8'h00, 64'h88FF_6655_4433_2211, "R5 masked lane differs");
        access(32'h3000_0000, 8'hFF, 0, 8'h00, 64'h8877_6655_4433_22EE, "R5 compared lane differs");
        access(32'h3000_0000, 8'hF0, 0, 8'h00, 64'h8877_6655_4433_22EE, "R5 differing lane not accessed");
        access(32'h3000_0000, 8'hFF, 1, 8'h00, 64'h8877_6655_4433_2211, "R10 store imprecise");

        // R6: direction exclusion on channel 3
        prog(3, 3'd0, 64'h4000_0000);
        prog(3, 3'd4, 64'hFF00);
        prog(3, 3'd5, C_EN | C_NS);
        access(32'h4000_0000, 8'h01, 1, 8'h00, 64'h0, "R6 store blocked");
        access(32'h4000_0000, 8'h01, 0, 8'h00, 64'h0, "R6 load passes");
        prog(3, 3'd5, C_EN | C_NL);
        access(32'h4000_0000, 8'h01, 0, 8'h00, 64'h0, "R6 load blocked");
        access(32'h4000_0000, 8'h01, 1, 8'h00, 64'h0, "R6 store passes");

        // R9: sticky status and clear
        check_status("R9 accumulated");
        clear_status(4'b1110);
        check_status("R9 clear bit0");
        clear_status(4'b1111);
        check_status("R9 write ones no effect");
        // hit racing a clear on channel 1
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h2000_0000; acc_be = 8'h01; acc_store = 0;
        acc_asid = 8'h00; acc_data = 0;
        sts_we = 1'b1; sts_wdata = 4'b0000;
        begin
            exp_t e;
            e = model(32'h2000_0000, 8'h01, 0, 8'h00, 64'h0, "R9 race hit");
            sts_model = (sts_model & 4'b0000) | e.hit;
            exp_q.push_back(e);
        end
        @(negedge clk);
        acc_valid = 1'b0; sts_we = 1'b0;
        check_status("R9 hit wins over clear");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2", "results outstanding", 64'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule